// File: doc/BRIEF.md
# Character-Row Video Display Controller

This block drives a monochrome text display. It generates a fixed raster of pixel clocks and scanlines. On every visible scanline it takes the shared memory bus away from the CPU with a HOLD request. It then reads one character byte per character cell and serializes each byte into pixels. Horizontal sync is decoded from the pixel counter. At each frame wrap the block raises an interrupt toward the CPU for the length of one line.

Two inputs gate the display. A video enable input is sampled at the start of each line. When it is low, that line gets no HOLD and no memory reads, and it shows background (white). A reserved character code marks the end of the text on a line. Once that code has been read, fetching stops, HOLD drops, and the remaining cells of that line show background. A small control register, written through a byte port, selects inverse video, a forced blank, and whether the frame interrupt is raised.

The memory data port is read in the same cycle as a read strobe. The byte it returns is taken to be the pixel pattern for the cell. `COLS`, `ROW_LINES` and the character width must be powers of two.

Top module: `vdc_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hold`, `mem_rd`, `pix`, `hsync` and `irq` are 0, and `ctl_rdata` reads 8'h04 (interrupt enabled, no inverse, no blank).
- R2: On a line with line counter below `V_VISIBLE` whose line start (pixel count 0) saw `videna` high, `hold` is 1 from pixel count 1. The first read strobe comes at pixel count 1+`HOLD_DELAY`, that is `HOLD_DELAY` clocks after `hold` rises. `mem_rd` is never 1 without `hold`.
- R3: Reads on such a line occur every 8 pixel counts, one per column. The address is `(line/ROW_LINES)*COLS + column`. `hold` falls in the cycle after the read of column `COLS-1`.
- R4: The byte read for column k is shown on `pix` MSB first, in the 8 cycles that follow its read cycle. `pix`=1 is foreground (dark) and `pix`=0 is background (white). Outside character cells `pix` is 0.
- R5: When the byte read equals `BEOL_CODE` (default 8'h7F), no further reads occur on that line and `hold` is 0 from the next cycle. `pix` is 0 from that cell to the end of the line.
- R6: With `videna` low at a line start, that line has no `hold`, no `mem_rd` and `pix`=0 throughout. A change of `videna` during a line takes effect only at the next line start.
- R7: `hsync` is 1 exactly at pixel counts 279 through 304 (`HS_START`..`HS_END`) on every line, blanking lines included.
- R8: `irq` becomes 1 at the start of line 0 after each frame wrap if control bit 2 was set at the wrap. It stays high for exactly `H_TOTAL` cycles. Otherwise it stays 0.
- R9: Control bit 0 inverts `pix` inside character cells only.
- R10: Control bit 1 forces `pix` to 0 while fetching and `hold` continue unchanged.
- R11: Control bits 7..3 are ignored on write and read back as 0. A write takes effect from the next cycle.
- R12: Lines at or beyond `V_VISIBLE` never raise `hold` or `mem_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| videna | input | 1 | Video enable, sampled at each line start |
| ctl_we | input | 1 | Control byte write strobe |
| ctl_wdata | input | 8 | Control byte write data |
| ctl_rdata | output | 8 | Control byte read-back |
| mem_data | input | 8 | Shared memory read data, valid in the strobe cycle |
| hold | output | 1 | Bus request to the CPU |
| mem_rd | output | 1 | Character read strobe |
| mem_addr | output | ADDR_W | Character cell address |
| pix | output | 1 | Serialized pixel, 1 = foreground |
| hsync | output | 1 | Horizontal sync |
| irq | output | 1 | Frame interrupt, one line long |

## Verification
The hardest situation to reach from the ports is an end-of-line code that lands exactly on column 0 or on the last column, combined with `videna` changing partway through a line. The first case leaves one read and a `hold` pulse of only 1+`HOLD_DELAY` cycles. The second must not disturb the line already in progress. The stimulus sets a per-row end-of-line column and a fresh memory pattern during every vertical blank, with directed frames for column 0, the last column and no terminator. In the random frames it toggles `videna` and writes control bytes in arbitrary cycles, so line starts are sampled with either value.

// File: rtl/vdc_pkg.sv
// Shared types for the character-row video controller.
package vdc_pkg;
    localparam int CHAR_W = 8;

    // Control register, bit 0 inverse, bit 1 forced blank, bit 2 interrupt enable.
    typedef struct packed {
        logic irq_en;
        logic blank;
        logic inv;
    } vdc_ctl_t;
endpackage

// File: rtl/vdc_timing.sv
// Raster timing: pixel and line counters, horizontal sync decode and the
// one-line frame interrupt. Assumes HS_START <= HS_END < H_TOTAL.
module vdc_timing #(
    parameter int H_TOTAL  = 342,
    parameter int V_TOTAL  = 20,
    parameter int HS_START = 279,
    parameter int HS_END   = 304,
    parameter int HW       = $clog2(H_TOTAL),
    parameter int VW       = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic          hsync,
    output logic          irq
);
    logic line_end;
    logic frame_end;

    assign line_end  = (hcnt == HW'(H_TOTAL - 1));
    assign frame_end = line_end && (vcnt == VW'(V_TOTAL - 1));

    // Advance the pixel counter and wrap lines and frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt <= '0;
            vcnt <= '0;
        end else if (line_end) begin
            hcnt <= '0;
            vcnt <= frame_end ? '0 : vcnt + 1'b1;
        end else begin
            hcnt <= hcnt + 1'b1;
        end
    end

    // Raise the interrupt at frame wrap and drop it after one line.
    always_ff @(posedge clk) begin
        if (!rst_n)         irq <= 1'b0;
        else if (frame_end) irq <= irq_en;
        else if (line_end)  irq <= 1'b0;
    end

    // Sync is a plain window on the pixel counter.
    assign hsync = (hcnt >= HW'(HS_START)) && (hcnt <= HW'(HS_END));
endmodule

// File: rtl/vdc_fetch.sv
// Bus request and character fetch sequencer. Assumes that HOLD is granted
// HOLD_DELAY clocks after it is raised (no acknowledge input) and that memory
// answers in the strobe cycle. COLS and ROW_LINES are powers of two.
module vdc_fetch
    import vdc_pkg::*;
#(
    parameter int          COLS       = 32,
    parameter int          ROW_LINES  = 8,
    parameter int          V_VISIBLE  = 16,
    parameter int          HOLD_DELAY = 4,
    parameter logic [7:0]  BEOL_CODE  = 8'h7F,
    parameter int          HW         = 9,
    parameter int          VW         = 5,
    parameter int          ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              videna,
    input  logic [HW-1:0]     hcnt,
    input  logic [VW-1:0]     vcnt,
    input  logic [7:0]        mem_data,
    output logic              hold,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              load,
    output logic [7:0]        load_data
);
    localparam int CW     = $clog2(COLS);
    localparam int LW     = $clog2(ROW_LINES);
    localparam int RW     = ADDR_W - CW;
    localparam int FETCH0 = 1 + HOLD_DELAY;

    logic [CW-1:0] col_q;
    logic [HW-1:0] slot_pos;
    logic [RW-1:0] row_idx;
    logic          line_go;
    logic          is_beol;

    assign line_go  = (hcnt == '0) && (vcnt < VW'(V_VISIBLE)) && videna;
    assign slot_pos = HW'(FETCH0) + HW'(col_q) * HW'(CHAR_W);
    assign mem_rd   = hold && (hcnt == slot_pos);
    assign row_idx  = RW'(vcnt >> LW);
    assign mem_addr = {row_idx, col_q};
    assign is_beol  = (mem_data == BEOL_CODE);

    // Request the bus at line start, step columns, release on last or terminator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold  <= 1'b0;
            col_q <= '0;
        end else if (line_go) begin
            hold  <= 1'b1;
            col_q <= '0;
        end else if (mem_rd) begin
            if (is_beol || col_q == CW'(COLS - 1)) hold <= 1'b0;
            else                                   col_q <= col_q + 1'b1;
        end
    end

    // Hand a fetched pattern byte to the serializer unless it ends the line.
    assign load      = mem_rd && !is_beol;
    assign load_data = mem_data;
endmodule

// File: rtl/vdc_shifter.sv
// Pixel serializer: loads one pattern byte and emits it MSB first over the
// next CHAR_W cycles, then shows background until the next load.
module vdc_shifter
    import vdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] load_data,
    input  logic       inv,
    input  logic       blank,
    output logic       pix
);
    localparam int NW = $clog2(CHAR_W + 1);

    logic [CHAR_W-1:0] sh_q;
    logic [NW-1:0]     left_q;

    // Load a new byte or shift out the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= load_data;
            left_q <= NW'(CHAR_W);
        end else if (left_q != '0) begin
            sh_q   <= {sh_q[CHAR_W-2:0], 1'b0};
            left_q <= left_q - 1'b1;
        end
    end

    // Apply inverse inside cells and the forced blank everywhere.
    assign pix = (left_q != '0) && !blank && (sh_q[CHAR_W-1] ^ inv);
endmodule

// File: rtl/vdc_top.sv
// Character-row video controller top: control register plus raster timing,
// fetch sequencer and pixel serializer.
module vdc_top
    import vdc_pkg::*;
#(
    parameter int          H_TOTAL    = 342,
    parameter int          V_TOTAL    = 20,
    parameter int          V_VISIBLE  = 16,
    parameter int          ROW_LINES  = 8,
    parameter int          COLS       = 32,
    parameter int          HOLD_DELAY = 4,
    parameter int          HS_START   = 279,
    parameter int          HS_END     = 304,
    parameter logic [7:0]  BEOL_CODE  = 8'h7F,
    parameter int          ADDR_W     = $clog2(V_VISIBLE / ROW_LINES * COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              videna,
    input  logic              ctl_we,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic [7:0]        mem_data,
    output logic              hold,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              pix,
    output logic              hsync,
    output logic              irq
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);

    vdc_ctl_t      ctl_q;
    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic          load;
    logic [7:0]    load_data;
    logic          unused_wdata_hi;

    assign unused_wdata_hi = ^ctl_wdata[7:3];

    // Control register; only the three low bits are kept.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '{irq_en: 1'b1, blank: 1'b0, inv: 1'b0};
        else if (ctl_we) ctl_q <= vdc_ctl_t'(ctl_wdata[2:0]);
    end

    assign ctl_rdata = {5'b0, ctl_q};

    vdc_timing #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL),
        .HS_START(HS_START), .HS_END(HS_END), .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .irq_en(ctl_q.irq_en),
        .hcnt(hcnt), .vcnt(vcnt), .hsync(hsync), .irq(irq)
    );

    vdc_fetch #(
        .COLS(COLS), .ROW_LINES(ROW_LINES), .V_VISIBLE(V_VISIBLE),
        .HOLD_DELAY(HOLD_DELAY), .BEOL_CODE(BEOL_CODE),
        .HW(HW), .VW(VW), .ADDR_W(ADDR_W)
    ) u_fetch (
        .clk(clk), .rst_n(rst_n), .videna(videna), .hcnt(hcnt), .vcnt(vcnt),
        .mem_data(mem_data), .hold(hold), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .load(load), .load_data(load_data)
    );

    vdc_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
        .inv(ctl_q.inv), .blank(ctl_q.blank), .pix(pix)
    );
endmodule

// File: rtl/vdc_checker.sv
// Port-level properties of the video controller, bound into vdc_top.
module vdc_checker #(
    parameter int         H_TOTAL   = 342,
    parameter logic [7:0] BEOL_CODE = 8'h7F
) (
    input logic       clk,
    input logic       rst_n,
    input logic       videna,
    input logic [7:0] ctl_rdata,
    input logic [7:0] mem_data,
    input logic       hold,
    input logic       mem_rd,
    input logic       pix,
    input logic       hsync,
    input logic       irq
);
    logic [15:0] irq_run;

    // Length of the current interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)   irq_run <= '0;
        else if (irq) irq_run <= irq_run + 1'b1;
        else          irq_run <= '0;
    end

    a_r2_read_under_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> hold);

    a_r6_hold_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold) |-> $past(videna));

    a_r5_beol_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_data == BEOL_CODE) |=> !hold);

    a_r7_sync_outside_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> !hold);

    a_r8_irq_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> (irq_run == 16'(H_TOTAL)));

    a_r10_blank_forces_bg: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[1] |-> !pix);
endmodule

bind vdc_top vdc_checker #(.H_TOTAL(H_TOTAL), .BEOL_CODE(BEOL_CODE)) u_vdc_checker (
    .clk(clk), .rst_n(rst_n), .videna(videna), .ctl_rdata(ctl_rdata),
    .mem_data(mem_data), .hold(hold), .mem_rd(mem_rd), .pix(pix),
    .hsync(hsync), .irq(irq)
);

// File: tb/test_vdc_top.sv
module test_vdc_top;
    localparam int H_TOTAL = 342, V_TOTAL = 20, V_VISIBLE = 16, ROW_LINES = 8;
    localparam int COLS = 32, HOLD_DELAY = 4, HS_START = 279, HS_END = 304;
    localparam logic [7:0] BEOL = 8'h7F;
    localparam int ROWS = V_VISIBLE / ROW_LINES;
    localparam int FETCH0 = 1 + HOLD_DELAY;
    localparam int FRAME = H_TOTAL * V_TOTAL;

    logic clk = 1'b0, rst_n = 1'b0, videna = 1'b1, ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0, ctl_rdata, mem_data;
    logic hold, mem_rd, pix, hsync, irq;
    logic [5:0] mem_addr;

    int n_chk = 0, n_fail = 0;
    int salt = 0;
    int beol_col [ROWS];

    // reference state
    int m_h = 0, m_v = 0;
    logic m_line_on = 1'b0, m_irq = 1'b0;
    logic [2:0] m_ctl = 3'b100;

    always #4 clk = ~clk;

    vdc_top i_vdc_top (
        .clk(clk), .rst_n(rst_n), .videna(videna), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .mem_data(mem_data),
        .hold(hold), .mem_rd(mem_rd), .mem_addr(mem_addr), .pix(pix),
        .hsync(hsync), .irq(irq)
    );

    function automatic logic [7:0] mem_model(int addr);
        int r = addr / COLS, c = addr % COLS;
        logic [7:0] v;
        if (c == beol_col[r]) return BEOL;
        v = 8'((addr * 37) + (salt * 11) + 5);
        if (v == BEOL) v = v ^ 8'h01;
        return v;
    endfunction

    always_comb mem_data = mem_model(int'(mem_addr));

    function automatic int last_col(int row);
        return (beol_col[row] < COLS) ? beol_col[row] : COLS - 1;
    endfunction

    function automatic logic exp_hold(int h, int v, logic on);
        if (!on || v >= V_VISIBLE) return 1'b0;
        return (h >= 1) && (h <= FETCH0 + 8 * last_col(v / ROW_LINES));
    endfunction

    function automatic logic exp_rd(int h, int v, logic on);
        if (!on || v >= V_VISIBLE || h < FETCH0) return 1'b0;
        return ((h - FETCH0) % 8 == 0) && ((h - FETCH0) / 8 <= last_col(v / ROW_LINES));
    endfunction

    function automatic logic exp_pix(int h, int v, logic on, logic [2:0] ctl);
        int k, row;
        logic [7:0] pat;
        if (!on || v >= V_VISIBLE || h < FETCH0 + 1 || ctl[1]) return 1'b0;
        row = v / ROW_LINES;
        k = (h - FETCH0 - 1) / 8;
        if (k >= COLS || k >= beol_col[row]) return 1'b0;
        pat = mem_model(row * COLS + k);
        return pat[7 - (h - FETCH0 - 1) % 8] ^ ctl[0];
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at line %0d pix %0d: got %0h expected %0h", req, m_v, m_h, act, exp);
        end
    endtask

    // reference model of counters, line sampling, control and interrupt
    always @(posedge clk) begin
        if (!rst_n) begin
            m_h <= 0; m_v <= 0; m_line_on <= 1'b0; m_irq <= 1'b0; m_ctl <= 3'b100;
        end else begin
            if (ctl_we) m_ctl <= ctl_wdata[2:0];
            if (m_h == 0) m_line_on <= videna && (m_v < V_VISIBLE);
            if (m_h == H_TOTAL - 1 && m_v == V_TOTAL - 1) m_irq <= m_ctl[2];
            else if (m_h == H_TOTAL - 1) m_irq <= 1'b0;
            if (m_h == H_TOTAL - 1) begin
                m_h <= 0;
                m_v <= (m_v == V_TOTAL - 1) ? 0 : m_v + 1;
            end else m_h <= m_h + 1;
        end
    end

    // compare every output away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2/R3/R5/R6/R12 hold", hold, exp_hold(m_h, m_v, m_line_on));
            check("R2/R3/R5/R6/R12 mem_rd", mem_rd, exp_rd(m_h, m_v, m_line_on));
            if (mem_rd)
                check("R3 mem_addr", mem_addr, (m_v / ROW_LINES) * COLS + (m_h - FETCH0) / 8);
            check("R4/R5/R9/R10 pix", pix, exp_pix(m_h, m_v, m_line_on, m_ctl));
            check("R7 hsync", hsync, (m_h >= HS_START) && (m_h <= HS_END));
            check("R8 irq", irq, m_irq);
            check("R11 ctl_rdata", ctl_rdata, {5'b0, m_ctl});
        end
    end

    task automatic write_ctl(logic [7:0] d);
        ctl_wdata = d; ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    initial begin
        $urandom(1234);
        foreach (beol_col[r]) beol_col[r] = COLS;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 reset hold", hold, 0);
        check("R1 reset mem_rd", mem_rd, 0);
        check("R1 reset pix", pix, 0);
        check("R1 reset hsync", hsync, 0);
        check("R1 reset irq", irq, 0);
        check("R1 reset ctl_rdata", ctl_rdata, 8'h04);
        rst_n = 1'b1;
        while (!(m_v == V_VISIBLE && m_h == 0)) @(negedge clk);
        for (int f = 0; f < 12; f++) begin
            salt = f * 7 + 3;
            case (f)
                0: begin foreach (beol_col[r]) beol_col[r] = COLS; videna = 1'b1; end
                1: begin beol_col[0] = 0; beol_col[1] = COLS - 1; end   // R5 edges
                2: begin beol_col[0] = 5; beol_col[1] = COLS; videna = 1'b0; end // R6
                3: begin videna = 1'b1; write_ctl(8'h05); end            // R9
                4: write_ctl(8'hFA);   // R10, R11: upper bits dropped, irq off (R8)
                5: write_ctl(8'h04);
                default: foreach (beol_col[r]) beol_col[r] = $urandom_range(COLS + 4, 0);
            endcase
            for (int c = 0; c < FRAME - ((f >= 3 && f <= 5) ? 1 : 0); c++) begin
                @(negedge clk);
                if (f >= 6) begin
                    if ($urandom_range(99, 0) < 2) videna = ~videna;
                    if (m_v < V_VISIBLE - 1 && $urandom_range(999, 0) < 2)
                        write_ctl(8'($urandom()) | 8'h04);
                end
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule